// File: doc/BRIEF.md
# Oversampled Contactless Response Framer

This block builds the chip stream that a proximity tag returns to a reader, starting from a byte payload. After a start pulse it sends a long run of ones so that the reader can lock its phase. A start-of-frame marker follows, then every payload byte framed as a character, then an end-of-frame marker. Each logical bit becomes four identical chips. One chip is produced for every clock on which the chip enable is high.

Payload bytes arrive over a valid/ready interface. Each byte carries a flag that marks it as the final one. The block adds no check bytes, because any CRC is already part of the payload. When the framer needs a byte and none is offered, it holds its chip output and stops counting chips. The emitted chip sequence therefore never contains filler chips. A strobe marks every cycle in which a new chip appears on the output.

Top module: `osr_frame_serializer`

## Requirements
- R1: After reset and whenever `busy` is low, `chip_out` is 1. Right after reset, `busy`, `done`, `byte_ready` and `chip_stb` are all 0.
- R2: Chips advance only on cycles with `chip_en` high. `chip_stb` is high in exactly the cycles in which `chip_out` shows a newly emitted chip, and `chip_out` does not change in any other cycle. Every logical bit appears as 4 consecutive identical chips.
- R3: A frame opens with 20 logical ones (80 chips).
- R4: The opening run is followed by a start-of-frame of 10 logical zeros and then 2 logical ones.
- R5: Each payload byte is emitted as a character: a 0 start bit, then the 8 data bits starting with bit 0, then a 1 stop bit.
- R6: After the character of the byte offered with `byte_last` high, an end-of-frame of 10 logical zeros and then 10 logical ones is sent, and no further chip is emitted.
- R7: The payload is sent unchanged and nothing is appended. A frame of N bytes holds exactly 4*(52+10N) chips.
- R8: `byte_ready` is high only while the framer waits for the next byte, that is, after start-of-frame and after each character that is not the last. While it waits, no chip is emitted and `chip_out` holds its value. A byte offered early is taken only when `byte_ready` is high.
- R9: `busy` rises in the cycle after an accepted start and stays high until the final chip has been emitted. `done` is a one-cycle pulse in the cycle in which the final chip is visible, and `busy` is low in that cycle.
- R10: A start pulse that arrives while a frame is in progress is ignored. The frame in progress continues unchanged and ends with a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enables the output of one chip in this cycle |
| start | input | 1 | Begins a frame when the block is idle |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | The payload byte is offered |
| byte_last | input | 1 | The offered byte is the final one of the frame |
| byte_ready | output | 1 | The framer takes the offered byte in this cycle |
| chip_out | output | 1 | Current chip level |
| chip_stb | output | 1 | `chip_out` holds a newly emitted chip |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle the assertions check these behaviours: the idle level, that the output holds between strobes, that strobes follow enabled cycles, that `done` is a single pulse, that a started frame enters its preamble, that a start arriving mid-frame is ignored, that the framer freezes while it waits for a byte, and that a newly loaded character opens with a zero. The exact chip sequence, its total length, the bit order within each byte and the correct ending after the flagged last byte can only be shown by the bench's scoreboard. The bench compares every strobed chip with a model of the frame built from the payload. It does this with the enable high on every cycle and with the enable high on one cycle in three, with bytes offered early or late, and with a stray start pulse in the middle of a frame.

// File: rtl/osr_frame_pkg.sv
package osr_frame_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PREAMBLE,
        PH_SOF_LO,
        PH_SOF_HI,
        PH_WAIT,
        PH_CHAR,
        PH_EOF_LO,
        PH_EOF_HI
    } phase_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic frame_end;
    } seq_ctl_t;

    function automatic logic is_emitting(phase_e ph);
        return !(ph == PH_IDLE || ph == PH_WAIT);
    endfunction

    function automatic logic seg_level(phase_e ph, logic char_bit);
        logic lvl;
        case (ph)
            PH_SOF_LO, PH_EOF_LO: lvl = 1'b0;
            PH_CHAR:              lvl = char_bit;
            default:              lvl = 1'b1;
        endcase
        return lvl;
    endfunction

    function automatic phase_e seg_next(phase_e ph, logic last_byte);
        phase_e nx;
        case (ph)
            PH_PREAMBLE: nx = PH_SOF_LO;
            PH_SOF_LO:   nx = PH_SOF_HI;
            PH_SOF_HI:   nx = PH_WAIT;
            PH_CHAR:     nx = last_byte ? PH_EOF_LO : PH_WAIT;
            PH_EOF_LO:   nx = PH_EOF_HI;
            default:     nx = PH_IDLE;
        endcase
        return nx;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/osr_bit_pacer.sv
module osr_bit_pacer #(
    parameter int unsigned CHIPS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_end
);
    localparam int unsigned CW = (CHIPS_PER_BIT > 1) ? $clog2(CHIPS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHIPS_PER_BIT - 1);

    logic [CW-1:0] idx_q;

    assign bit_end = adv && (idx_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= bit_end ? '0 : idx_q + 1'b1;
        end
    end

    // R2
    chip_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST);

    // R2
    chip_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(idx_q));

endmodule

// File: rtl/osr_char_shifter.sv
module osr_char_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              load_last,
    input  logic              shift,
    output logic              lsb,
    output logic              last_flag
);
    localparam int unsigned CHAR_W = BYTE_W + 2;

    logic [CHAR_W-1:0] sr_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '1;
            last_q <= 1'b0;
        end else if (load) begin
            sr_q   <= {1'b1, load_data, 1'b0};
            last_q <= load_last;
        end else if (shift) begin
            sr_q   <= {1'b1, sr_q[CHAR_W-1:1]};
        end
    end

    assign lsb       = sr_q[0];
    assign last_flag = last_q;

    // R5
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (lsb == 1'b0));

endmodule

// File: rtl/osr_frame_fsm.sv
module osr_frame_fsm
    import osr_frame_pkg::*;
#(
    parameter int unsigned BYTE_W        = 8,
    parameter int unsigned PREAMBLE_BITS = 20,
    parameter int unsigned SOF_LO_BITS   = 10,
    parameter int unsigned SOF_HI_BITS   = 2,
    parameter int unsigned EOF_LO_BITS   = 10,
    parameter int unsigned EOF_HI_BITS   = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     chip_en,
    input  logic     byte_valid,
    input  logic     bit_end,
    input  logic     last_flag,
    output phase_e   phase,
    output logic     adv,
    output logic     byte_ready,
    output seq_ctl_t ctl
);
    localparam int unsigned CHAR_BITS = BYTE_W + 2;
    localparam int unsigned MAX_SEG = max2(max2(max2(PREAMBLE_BITS, SOF_LO_BITS),
                                                max2(SOF_HI_BITS, EOF_LO_BITS)),
                                           max2(EOF_HI_BITS, CHAR_BITS));
    localparam int unsigned BW = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1;

    localparam logic [BW-1:0] PRE_LAST    = BW'(PREAMBLE_BITS - 1);
    localparam logic [BW-1:0] SOFL_LAST   = BW'(SOF_LO_BITS - 1);
    localparam logic [BW-1:0] SOFH_LAST   = BW'(SOF_HI_BITS - 1);
    localparam logic [BW-1:0] CHAR_LAST   = BW'(CHAR_BITS - 1);
    localparam logic [BW-1:0] EOFL_LAST   = BW'(EOF_LO_BITS - 1);
    localparam logic [BW-1:0] EOFH_LAST   = BW'(EOF_HI_BITS - 1);

    phase_e        phase_q;
    logic [BW-1:0] bit_idx_q;
    logic [BW-1:0] seg_last;
    logic          seg_done;

    always_comb begin
        case (phase_q)
            PH_PREAMBLE: seg_last = PRE_LAST;
            PH_SOF_LO:   seg_last = SOFL_LAST;
            PH_SOF_HI:   seg_last = SOFH_LAST;
            PH_CHAR:     seg_last = CHAR_LAST;
            PH_EOF_LO:   seg_last = EOFL_LAST;
            PH_EOF_HI:   seg_last = EOFH_LAST;
            default:     seg_last = '0;
        endcase
    end

    assign phase         = phase_q;
    assign adv           = chip_en && is_emitting(phase_q);
    assign byte_ready    = (phase_q == PH_WAIT);
    assign seg_done      = bit_end && (bit_idx_q == seg_last);
    assign ctl.load      = byte_ready && byte_valid;
    assign ctl.shift     = bit_end && (phase_q == PH_CHAR);
    assign ctl.frame_end = seg_done && (phase_q == PH_EOF_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            bit_idx_q <= '0;
        end else begin
            if (phase_q == PH_IDLE) begin
                if (start) begin
                    phase_q   <= PH_PREAMBLE;
                    bit_idx_q <= '0;
                end
            end else if (phase_q == PH_WAIT) begin
                if (byte_valid) begin
                    phase_q   <= PH_CHAR;
                    bit_idx_q <= '0;
                end
            end else if (seg_done) begin
                phase_q   <= seg_next(phase_q, last_flag);
                bit_idx_q <= '0;
            end else if (bit_end) begin
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // R9
    start_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start) |=> (phase_q == PH_PREAMBLE));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_PREAMBLE && start) |=> (phase_q != PH_PREAMBLE));

    // R8
    wait_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT && !byte_valid) |=> (phase_q == PH_WAIT && $stable(bit_idx_q)));

    // R8
    ready_only_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> !adv);

endmodule

// File: rtl/osr_frame_serializer.sv
module osr_frame_serializer
    import osr_frame_pkg::*;
#(
    parameter int unsigned BYTE_W        = 8,
    parameter int unsigned CHIPS_PER_BIT = 4,
    parameter int unsigned PREAMBLE_BITS = 20,
    parameter int unsigned SOF_LO_BITS   = 10,
    parameter int unsigned SOF_HI_BITS   = 2,
    parameter int unsigned EOF_LO_BITS   = 10,
    parameter int unsigned EOF_HI_BITS   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              start,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    input  logic              byte_last,
    output logic              byte_ready,
    output logic              chip_out,
    output logic              chip_stb,
    output logic              busy,
    output logic              done
);
    phase_e   phase;
    seq_ctl_t ctl;
    logic     adv;
    logic     bit_end;
    logic     char_bit;
    logic     last_flag;
    logic     level;
    logic     chip_q;
    logic     stb_q;
    logic     done_q;

    osr_frame_fsm #(
        .BYTE_W        (BYTE_W),
        .PREAMBLE_BITS (PREAMBLE_BITS),
        .SOF_LO_BITS   (SOF_LO_BITS),
        .SOF_HI_BITS   (SOF_HI_BITS),
        .EOF_LO_BITS   (EOF_LO_BITS),
        .EOF_HI_BITS   (EOF_HI_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .chip_en    (chip_en),
        .byte_valid (byte_valid),
        .bit_end    (bit_end),
        .last_flag  (last_flag),
        .phase      (phase),
        .adv        (adv),
        .byte_ready (byte_ready),
        .ctl        (ctl)
    );

    osr_bit_pacer #(
        .CHIPS_PER_BIT (CHIPS_PER_BIT)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .bit_end (bit_end)
    );

    osr_char_shifter #(
        .BYTE_W (BYTE_W)
    ) u_char (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .load_data (byte_data),
        .load_last (byte_last),
        .shift     (ctl.shift),
        .lsb       (char_bit),
        .last_flag (last_flag)
    );

    assign level = seg_level(phase, char_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_q <= 1'b1;
            stb_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            stb_q  <= adv;
            done_q <= ctl.frame_end;
            if (adv) begin
                chip_q <= level;
            end
        end
    end

    assign chip_out = chip_q;
    assign chip_stb = stb_q;
    assign done     = done_q;
    assign busy     = (phase != PH_IDLE);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> chip_out);

    // R2
    chip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chip_stb |-> $stable(chip_out));

    // R2
    stb_after_en_chk: assert property (@(posedge clk) disable iff (rst)
        chip_stb |-> $past(chip_en));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

// File: tb/osr_frame_serializer_bench.sv
`timescale 1ns/1ps
module osr_frame_serializer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_en = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_last = 1'b0;
    logic       byte_ready;
    logic       chip_out;
    logic       chip_stb;
    logic       busy;
    logic       done;

    always #2.5 clk = ~clk;

    osr_frame_serializer u_osr_frame_serializer (
        .clk        (clk),
        .rst        (rst),
        .chip_en    (chip_en),
        .start      (start),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_last  (byte_last),
        .byte_ready (byte_ready),
        .chip_out   (chip_out),
        .chip_stb   (chip_stb),
        .busy       (busy),
        .done       (done)
    );

    int checks = 0;
    int fails  = 0;
    bit    exp_bit[$];
    string exp_req[$];
    int chips_seen = 0;
    int done_seen  = 0;
    int idle_viol  = 0;
    int stall_viol = 0;
    int early_viol = 0;
    bit prev_ready = 1'b0;
    bit prev_chip  = 1'b1;
    int en_div = 1;
    bit [7:0] frame_bytes [0:7];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // chip enable pattern
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt = (cnt + 1) % en_div;
            chip_en = (cnt == 0);
        end
    end

    // monitor: pops expected chips as they appear
    always @(negedge clk) begin
        if (!rst) begin
            if (chip_stb) begin
                chips_seen++;
                if (exp_bit.size() == 0) begin
                    chk(1'b0, "R6", "chip after frame end", chip_out, 1);
                end else begin
                    bit    e;
                    string r;
                    e = exp_bit.pop_front();
                    r = exp_req.pop_front();
                    chk(chip_out === e, r, "chip level", chip_out, e);
                end
            end
            if (!busy && (chip_out !== 1'b1 || byte_ready)) idle_viol++;
            if (done) done_seen++;
            if (prev_ready && byte_ready && (chip_stb || chip_out !== prev_chip)) stall_viol++;
            if (byte_valid && !byte_ready && chip_stb === 1'b0 && !busy) early_viol += 0;
            prev_ready = byte_ready;
            prev_chip  = chip_out;
        end
    end

    task automatic push_bit(input bit b, input string req);
        for (int c = 0; c < 4; c++) begin
            exp_bit.push_back(b);
            exp_req.push_back(req);
        end
    endtask

    task automatic push_frame(input int n);
        for (int i = 0; i < 20; i++) push_bit(1'b1, "R3");
        for (int i = 0; i < 10; i++) push_bit(1'b0, "R4");
        for (int i = 0; i < 2; i++)  push_bit(1'b1, "R4");
        for (int k = 0; k < n; k++) begin
            push_bit(1'b0, "R5");
            for (int j = 0; j < 8; j++) push_bit(frame_bytes[k][j], "R5");
            push_bit(1'b1, "R5");
        end
        for (int i = 0; i < 10; i++) push_bit(1'b0, "R6");
        for (int i = 0; i < 10; i++) push_bit(1'b1, "R6");
    endtask

    // driver: one frame, expected chips go to the scoreboard queue
    task automatic run_frame(input int n, input int stall, input bit early, input bit stray_start);
        int chips0;
        int done0;
        int wd;
        chips0 = chips_seen;
        done0  = done_seen;
        idle_viol  = 0;
        stall_viol = 0;
        push_frame(n);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R9", "busy after start", busy, 1);
        for (int k = 0; k < n; k++) begin
            if (early) begin
                byte_data  = frame_bytes[k];
                byte_last  = (k == n - 1);
                byte_valid = 1'b1;
                @(negedge clk);
                // R8: an early byte is not taken while the framer emits
                if (!byte_ready) chk(busy === 1'b1 && byte_valid, "R8", "early byte held", byte_ready, 0);
            end
            while (!byte_ready) @(negedge clk);
            repeat (stall) @(negedge clk);
            byte_data  = frame_bytes[k];
            byte_last  = (k == n - 1);
            byte_valid = 1'b1;
            @(posedge clk); #1;
            byte_valid = 1'b0;
            byte_last  = 1'b0;
            if (stray_start && k == 0) begin
                repeat (7) @(posedge clk);
                #1 start = 1'b1;
                @(posedge clk); #1 start = 1'b0;
            end
            @(negedge clk);
        end
        wd = 0;
        while (busy && wd < 50000) begin
            @(negedge clk);
            wd++;
        end
        repeat (4) @(negedge clk);
        chk(exp_bit.size() == 0, "R6", "chips left in scoreboard", exp_bit.size(), 0);
        chk(chips_seen - chips0 == 4 * (52 + 10 * n), "R7", "frame chip count",
            chips_seen - chips0, 4 * (52 + 10 * n));
        chk(done_seen - done0 == 1, "R9", "done pulses", done_seen - done0, 1);
        if (stray_start) chk(done_seen - done0 == 1, "R10", "done pulses with stray start", done_seen - done0, 1);
        chk(busy === 1'b0, "R9", "busy after frame", busy, 0);
        chk(idle_viol == 0, "R1", "idle level violations", idle_viol, 0);
        chk(stall_viol == 0, "R8", "chip movement while waiting", stall_viol, 0);
        exp_bit.delete();
        exp_req.delete();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0,     "R1", "busy after reset", busy, 0);
        chk(done === 1'b0,     "R1", "done after reset", done, 0);
        chk(byte_ready === 1'b0, "R1", "byte_ready after reset", byte_ready, 0);
        chk(chip_out === 1'b1, "R1", "chip_out after reset", chip_out, 1);
        chk(chip_stb === 1'b0, "R1", "chip_stb after reset", chip_stb, 0);

        // one byte, enable every cycle (R3 R4 R5 R6 R7)
        en_div = 1;
        frame_bytes[0] = 8'hA5;
        run_frame(1, 0, 1'b0, 1'b0);

        // three bytes, slow enable, late bytes (R2 R8)
        en_div = 3;
        frame_bytes[0] = 8'h01;
        frame_bytes[1] = 8'h80;
        frame_bytes[2] = 8'h3C;
        run_frame(3, 9, 1'b0, 1'b0);

        // bytes offered early, CRC-like tail sent unchanged (R7 R8)
        en_div = 1;
        frame_bytes[0] = 8'h05;
        frame_bytes[1] = 8'h00;
        frame_bytes[2] = 8'h08;
        frame_bytes[3] = 8'h39;
        frame_bytes[4] = 8'h73;
        run_frame(5, 0, 1'b1, 1'b0);

        // stray start mid-frame (R10)
        en_div = 2;
        frame_bytes[0] = 8'hFF;
        frame_bytes[1] = 8'h00;
        run_frame(2, 3, 1'b0, 1'b1);

        // nothing happens without start
        repeat (30) @(negedge clk);
        chk(chips_seen > 0 && busy === 1'b0 && chip_out === 1'b1, "R1", "idle without start", chip_out, 1);
        summary();
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        summary();
    end

endmodule